// File: doc/BRIEF.md
# Synchronized Deadlock Recovery Controller

This controller sits beside one router of a single-virtual-channel network and recovers the router from routing deadlocks. A stall timer measures how long the head packet of the input buffer has stayed blocked. When it reaches a programmable threshold, the router becomes an initiator. It sends a probe out of the port that the blocked packet is waiting on. Every blocked router forwards the probe along its own dependency. A probe that comes back to its sender proves that the dependency is cyclic.

After the initiator confirms the cycle, it sends a schedule message around the loop. The message carries a spin time equal to the current cycle count plus a fixed margin. Each router that receives it locks onto that time. In that cycle every locked router raises its spin strobe, and the external datapath moves the blocked packet one hop forward. All routers on the loop therefore move together. If the initiator is still blocked after the spin, it sends a combined check-and-schedule message that arranges the next spin. Special messages share the regular links and have priority over flits. They are never stored: a router forwards each one in the next cycle or drops it.

When initiators contend, the lower router ID wins. A router that is locked onto a spin drops probes. An initiator whose probe does not come back in time returns to idle and starts timing again.

Top module: `deadlock_spin_ctrl`

## Requirements
- R1: After reset no message is sent and the spin strobe is low. While `blocked` stays high in the idle state, the stall count rises by one per cycle. On the clock edge that sees the count at or above `threshold`, the controller registers a probe. The probe has kind 1, source `my_id`, and port `head_port`, so it appears THRESHOLD+1 edges after `blocked` rises.
- R2: A cycle with `blocked` low clears the stall count, so the full threshold must pass again before a probe.
- R3: A foreign probe that arrives while the router is blocked and not contending is copied unchanged (kind, source, time) to the output in the next cycle, on `head_port`. It is dropped when the router is not blocked. An own-ID probe that arrives while the router is idle is dropped. Kind 0 is never forwarded.
- R4: When the router's own probe returns while it waits for one, the next cycle carries a schedule message. The message has kind 2, source `my_id`, and time equal to the sampled `cycle_now` plus MARGIN. The router locks onto that time.
- R5: A foreign kind-2 or kind-3 message that arrives while the router is blocked and not locked is forwarded, and it locks the router onto the carried time. `spin_go` is high exactly while `cycle_now` equals the locked time.
- R6: `spin_go` lasts one cycle. After the spin, a non-initiator returns to idle with a cleared stall count, so its next probe comes THRESHOLD+1 edges after the spin edge.
- R7: An initiator that is still blocked after its spin sends, one edge later, a message of kind 3 with time equal to the sampled `cycle_now` plus MARGIN. When that message returns, the initiator locks onto the carried time and spins again. If `blocked` is low after the spin, the initiator sends nothing.
- R8: While probing, the router drops a probe from a higher ID. It forwards a probe from a lower ID and gives up its own attempt. While locked, it drops every probe.
- R9: If the router's own probe has not returned RET_TIMEOUT edges after launch, the router returns to idle with a cleared stall count. The next probe appears RET_TIMEOUT+THRESHOLD+1 edges after the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| my_id | input | ID_W | This router's ID |
| threshold | input | CNT_W | Stall cycles before a probe is launched |
| cycle_now | input | TIME_W | Network-wide cycle count |
| blocked | input | 1 | Head packet present and not leaving |
| head_port | input | PORT_W | Output port the head packet waits on |
| msg_in_valid | input | 1 | Special message arriving this cycle |
| msg_in_kind | input | 2 | 1 probe, 2 schedule, 3 check-and-schedule |
| msg_in_src | input | ID_W | Initiator ID of the arriving message |
| msg_in_time | input | TIME_W | Spin time carried by the message |
| msg_out_valid | output | 1 | Special message leaving this cycle |
| msg_out_kind | output | 2 | Kind of the outgoing message |
| msg_out_src | output | ID_W | Initiator ID of the outgoing message |
| msg_out_time | output | TIME_W | Spin time carried out |
| msg_out_port | output | PORT_W | Port that the outgoing message takes |
| spin_go | output | 1 | Move the blocked packet one hop now |

## Verification
The assertions assume that `cycle_now` advances by exactly one per clock, so an equality match cannot last two cycles. They also assume that `my_id` is constant and that every arriving message is a single-cycle pulse. The bench updates `cycle_now` with a nonblocking increment on every rising edge and ties `my_id` to 5. It drives each message for one edge only and clears it right after that edge, and it changes `blocked` only between edges.

// File: rtl/dsc_pkg.sv
package dsc_pkg;
  typedef enum logic [1:0] {
    K_NONE  = 2'd0,
    K_PROBE = 2'd1,
    K_MOVE  = 2'd2,
    K_PMOVE = 2'd3
  } msg_kind_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PROBE,
    ST_LOCK,
    ST_PMSEND,
    ST_PMWAIT
  } dsc_state_e;
endpackage

// File: rtl/dsc_stall_timer.sv
module dsc_stall_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             clr,
  input  logic             blocked,
  input  logic [CNT_W-1:0] threshold,
  output logic             expired
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  cnt <= '0;
    else if (clr || !blocked)    cnt <= '0;
    else if (en && cnt != CNT_MAX) cnt <= cnt + 1'b1;
  end

  assign expired = en && blocked && (cnt >= threshold);
endmodule

// File: rtl/dsc_spin_timer.sv
module dsc_spin_timer #(
  parameter int TIME_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [TIME_W-1:0] load_time,
  input  logic [TIME_W-1:0] cycle_now,
  output logic              hit
);
  logic [TIME_W-1:0] target;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    target <= '0;
    else if (load) target <= load_time;
  end

  assign hit = (target == cycle_now);
endmodule

// File: rtl/dsc_msg_filter.sv
module dsc_msg_filter
  import dsc_pkg::*;
#(
  parameter int ID_W = 4
) (
  input  dsc_state_e        st,
  input  logic              blocked,
  input  logic [ID_W-1:0]   my_id,
  input  logic              msg_in_valid,
  input  logic [1:0]        msg_in_kind,
  input  logic [ID_W-1:0]   msg_in_src,
  output logic              fwd,
  output logic              lock_req,
  output logic              abandon,
  output logic              own_probe_back,
  output logic              own_pm_back
);
  function automatic logic f_outranks(input logic [ID_W-1:0] a, input logic [ID_W-1:0] b);
    return a < b;
  endfunction

  logic foreign, contend, is_probe, is_sched;
  assign foreign  = (msg_in_src != my_id);
  assign contend  = (st == ST_PROBE) || (st == ST_PMWAIT);
  assign is_probe = (msg_in_kind == K_PROBE);
  assign is_sched = (msg_in_kind == K_MOVE) || (msg_in_kind == K_PMOVE);

  always_comb begin
    fwd = 1'b0; lock_req = 1'b0; abandon = 1'b0;
    own_probe_back = 1'b0; own_pm_back = 1'b0;
    if (msg_in_valid) begin
      if (is_probe) begin
        if (!foreign) own_probe_back = (st == ST_PROBE);
        else if (st != ST_LOCK && blocked) begin
          if (!contend || f_outranks(msg_in_src, my_id)) begin
            fwd     = 1'b1;
            abandon = (st == ST_PROBE);
          end
        end
      end else if (is_sched) begin
        if (!foreign) own_pm_back = (msg_in_kind == K_PMOVE) && (st == ST_PMWAIT);
        else if (st != ST_LOCK && blocked) begin
          fwd      = 1'b1;
          lock_req = 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/deadlock_spin_ctrl.sv
module deadlock_spin_ctrl
  import dsc_pkg::*;
#(
  parameter int ID_W        = 4,
  parameter int CNT_W       = 8,
  parameter int TIME_W      = 16,
  parameter int PORT_W      = 3,
  parameter int MARGIN      = 16,
  parameter int RET_TIMEOUT = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ID_W-1:0]   my_id,
  input  logic [CNT_W-1:0]  threshold,
  input  logic [TIME_W-1:0] cycle_now,
  input  logic              blocked,
  input  logic [PORT_W-1:0] head_port,
  input  logic              msg_in_valid,
  input  logic [1:0]        msg_in_kind,
  input  logic [ID_W-1:0]   msg_in_src,
  input  logic [TIME_W-1:0] msg_in_time,
  output logic              msg_out_valid,
  output logic [1:0]        msg_out_kind,
  output logic [ID_W-1:0]   msg_out_src,
  output logic [TIME_W-1:0] msg_out_time,
  output logic [PORT_W-1:0] msg_out_port,
  output logic              spin_go
);
  localparam int WAIT_W = $clog2(RET_TIMEOUT + 1);
  localparam logic [WAIT_W-1:0] WAIT_LAST = WAIT_W'(RET_TIMEOUT - 1);

  function automatic logic [TIME_W-1:0] f_spin_time(input logic [TIME_W-1:0] now);
    return now + TIME_W'(MARGIN);
  endfunction

  dsc_state_e st, st_n;
  logic init_q, init_n;
  logic [WAIT_W-1:0] wait_cnt;

  logic fwd, lock_req, abandon, own_probe_back, own_pm_back;
  logic expired, stall_clr, wait_clr, timeout_w, spin_hit;
  logic load, emit;
  logic [TIME_W-1:0] load_t, e_time;
  logic [1:0] e_kind;
  logic [ID_W-1:0] e_src;
  logic locked_w, launch_w;

  dsc_msg_filter #(.ID_W(ID_W)) u_filt (
    .st(st), .blocked(blocked), .my_id(my_id),
    .msg_in_valid(msg_in_valid), .msg_in_kind(msg_in_kind), .msg_in_src(msg_in_src),
    .fwd(fwd), .lock_req(lock_req), .abandon(abandon),
    .own_probe_back(own_probe_back), .own_pm_back(own_pm_back)
  );

  dsc_stall_timer #(.CNT_W(CNT_W)) u_stall (
    .clk(clk), .rst_n(rst_n), .en(st == ST_IDLE), .clr(stall_clr),
    .blocked(blocked), .threshold(threshold), .expired(expired)
  );

  dsc_spin_timer #(.TIME_W(TIME_W)) u_spin (
    .clk(clk), .rst_n(rst_n), .load(load), .load_time(load_t),
    .cycle_now(cycle_now), .hit(spin_hit)
  );

  assign locked_w  = (st == ST_LOCK);
  assign spin_go   = locked_w && spin_hit;
  assign timeout_w = (wait_cnt >= WAIT_LAST);
  assign launch_w  = emit && !fwd && (e_kind == K_PROBE);

  always_comb begin
    st_n = st; init_n = init_q;
    emit = 1'b0; e_kind = K_NONE; e_src = my_id; e_time = '0;
    load = 1'b0; load_t = msg_in_time;
    stall_clr = 1'b0; wait_clr = 1'b0;
    if (fwd) begin
      emit = 1'b1; e_kind = msg_in_kind; e_src = msg_in_src; e_time = msg_in_time;
    end
    unique case (st)
      ST_IDLE: begin
        if (lock_req) begin
          st_n = ST_LOCK; load = 1'b1; init_n = 1'b0;
        end else if (!fwd && expired) begin
          emit = 1'b1; e_kind = K_PROBE; st_n = ST_PROBE; wait_clr = 1'b1;
        end
      end
      ST_PROBE: begin
        if (own_probe_back) begin
          emit = 1'b1; e_kind = K_MOVE; e_time = f_spin_time(cycle_now);
          load = 1'b1; load_t = f_spin_time(cycle_now);
          st_n = ST_LOCK; init_n = 1'b1;
        end else if (lock_req) begin
          st_n = ST_LOCK; load = 1'b1; init_n = 1'b0;
        end else if (abandon || timeout_w) begin
          st_n = ST_IDLE; stall_clr = 1'b1;
        end
      end
      ST_LOCK: begin
        if (spin_go) begin
          stall_clr = 1'b1;
          st_n = init_q ? ST_PMSEND : ST_IDLE;
        end
      end
      ST_PMSEND: begin
        if (lock_req) begin
          st_n = ST_LOCK; load = 1'b1; init_n = 1'b0;
        end else if (!blocked) begin
          st_n = ST_IDLE; stall_clr = 1'b1;
        end else if (!fwd) begin
          emit = 1'b1; e_kind = K_PMOVE; e_time = f_spin_time(cycle_now);
          st_n = ST_PMWAIT; wait_clr = 1'b1;
        end
      end
      ST_PMWAIT: begin
        if (own_pm_back) begin
          st_n = ST_LOCK; load = 1'b1; init_n = 1'b1;
        end else if (lock_req) begin
          st_n = ST_LOCK; load = 1'b1; init_n = 1'b0;
        end else if (timeout_w) begin
          st_n = ST_IDLE; stall_clr = 1'b1;
        end
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; init_q <= 1'b0; wait_cnt <= '0;
      msg_out_valid <= 1'b0; msg_out_kind <= 2'd0; msg_out_src <= '0;
      msg_out_time <= '0; msg_out_port <= '0;
    end else begin
      st <= st_n; init_q <= init_n;
      if (wait_clr) wait_cnt <= '0;
      else if ((st == ST_PROBE || st == ST_PMWAIT) && !timeout_w) wait_cnt <= wait_cnt + 1'b1;
      msg_out_valid <= emit;
      msg_out_kind  <= e_kind;
      msg_out_src   <= e_src;
      msg_out_time  <= e_time;
      msg_out_port  <= head_port;
    end
  end
endmodule

// File: rtl/dsc_checks.sv
module dsc_checks #(
  parameter int ID_W   = 4,
  parameter int TIME_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ID_W-1:0]   my_id,
  input logic              blocked,
  input logic              msg_in_valid,
  input logic [1:0]        msg_in_kind,
  input logic [ID_W-1:0]   msg_in_src,
  input logic [TIME_W-1:0] msg_in_time,
  input logic              msg_out_valid,
  input logic [1:0]        msg_out_kind,
  input logic [ID_W-1:0]   msg_out_src,
  input logic [TIME_W-1:0] msg_out_time,
  input logic              spin_go,
  input logic              locked_w
);
  assert_fwd_unbuffered_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_out_valid && msg_out_src != my_id) |->
      ($past(msg_in_valid) && $past(msg_in_src) == msg_out_src && $past(msg_in_time) == msg_out_time));

  assert_kind_nonzero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    msg_out_valid |-> (msg_out_kind != 2'd0));

  assert_probe_needs_block_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_out_valid && msg_out_kind == 2'd1 && msg_out_src == my_id) |-> $past(blocked));

  assert_spin_one_cycle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    spin_go |=> !spin_go);

  assert_unlock_after_spin_R5: assert property (@(posedge clk) disable iff (!rst_n)
    spin_go |=> !locked_w);

  assert_locked_drops_probe_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (locked_w && msg_in_valid && msg_in_kind == 2'd1) |=> !(msg_out_valid && msg_out_kind == 2'd1));
endmodule

bind deadlock_spin_ctrl dsc_checks #(.ID_W(ID_W), .TIME_W(TIME_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .my_id(my_id), .blocked(blocked),
  .msg_in_valid(msg_in_valid), .msg_in_kind(msg_in_kind),
  .msg_in_src(msg_in_src), .msg_in_time(msg_in_time),
  .msg_out_valid(msg_out_valid), .msg_out_kind(msg_out_kind),
  .msg_out_src(msg_out_src), .msg_out_time(msg_out_time),
  .spin_go(spin_go), .locked_w(locked_w)
);

// File: tb/sim_deadlock_spin_ctrl.sv
`timescale 1ns/1ps
module sim_deadlock_spin_ctrl;
  localparam int ID_W = 4, CNT_W = 8, TIME_W = 16, PORT_W = 3;
  localparam int MARGIN = 16, RET_TIMEOUT = 32, THR = 5;
  localparam logic [ID_W-1:0] ME = 4'd5;

  logic clk = 0, rst_n = 0;
  logic [CNT_W-1:0] threshold = 8'd200;
  logic [TIME_W-1:0] now = '0;
  logic blocked = 0;
  logic [PORT_W-1:0] head_port = 3'd3;
  logic in_v = 0;
  logic [1:0] in_k = 0;
  logic [ID_W-1:0] in_s = 0;
  logic [TIME_W-1:0] in_t = 0;
  logic out_v, spin_go;
  logic [1:0] out_k;
  logic [ID_W-1:0] out_s;
  logic [TIME_W-1:0] out_t;
  logic [PORT_W-1:0] out_p;

  int tests = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;
  always @(posedge clk) now <= now + 1'b1;

  deadlock_spin_ctrl #(.ID_W(ID_W), .CNT_W(CNT_W), .TIME_W(TIME_W), .PORT_W(PORT_W),
    .MARGIN(MARGIN), .RET_TIMEOUT(RET_TIMEOUT)) u0 (
    .clk(clk), .rst_n(rst_n), .my_id(ME), .threshold(threshold), .cycle_now(now),
    .blocked(blocked), .head_port(head_port),
    .msg_in_valid(in_v), .msg_in_kind(in_k), .msg_in_src(in_s), .msg_in_time(in_t),
    .msg_out_valid(out_v), .msg_out_kind(out_k), .msg_out_src(out_s),
    .msg_out_time(out_t), .msg_out_port(out_p), .spin_go(spin_go));

  // kind[25:24] src[23:20] time[19:4] blocked[3] exp_valid[2] exp_kind[1:0]
  localparam logic [25:0] VEC [5] = '{
    {2'd1, 4'd2, 16'd100, 1'b1, 1'b1, 2'd1},
    {2'd1, 4'd2, 16'd101, 1'b0, 1'b0, 2'd0},
    {2'd1, 4'd5, 16'd102, 1'b1, 1'b0, 2'd0},
    {2'd3, 4'd7, 16'd103, 1'b0, 1'b0, 2'd0},
    {2'd0, 4'd2, 16'd104, 1'b1, 1'b0, 2'd0}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk); #1;
  endtask

  task automatic put_msg(input logic [1:0] k, input logic [ID_W-1:0] s, input logic [TIME_W-1:0] t);
    @(negedge clk);
    in_v = 1; in_k = k; in_s = s; in_t = t;
    tick();
    in_v = 0; in_k = 0;
  endtask

  task automatic do_reset;
    @(negedge clk); rst_n = 0; blocked = 0; in_v = 0;
    tick(); tick();
    @(negedge clk); rst_n = 1;
  endtask

  task automatic edges_to_probe(output int n);
    n = 0;
    for (int i = 0; i < 200; i++) begin
      tick(); n++;
      if (out_v && out_k == 2'd1 && out_s == ME) break;
    end
  endtask

  task automatic wait_spin(input logic [TIME_W-1:0] tgt, input string req);
    bit early = 0;
    for (int i = 0; i < 500 && now != tgt; i++) begin
      if (spin_go) early = 1;
      tick();
    end
    check(!early && spin_go, req, int'(spin_go), 1);
  endtask

  initial begin
    #(10 * 150000);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int n;
    logic [TIME_W-1:0] t0, t1;
    do_reset();
    tick();
    check(!out_v && !spin_go, "R1 reset", int'(out_v), 0);

    // table: single-message filtering on an idle router
    foreach (VEC[i]) begin
      @(negedge clk); blocked = VEC[i][3];
      put_msg(VEC[i][25:24], VEC[i][23:20], VEC[i][19:4]);
      check(out_v == VEC[i][2], "R3 table valid", int'(out_v), int'(VEC[i][2]));
      if (VEC[i][2])
        check(out_k == VEC[i][1:0] && out_s == VEC[i][23:20] && out_t == VEC[i][19:4] && out_p == 3'd3,
              "R3 table fields", int'(out_t), int'(VEC[i][19:4]));
    end

    // R1 threshold launch
    do_reset(); threshold = THR;
    @(negedge clk); blocked = 1;
    edges_to_probe(n);
    check(n == THR + 1, "R1 launch edge", n, THR + 1);
    check(out_p == 3'd3, "R1 probe port", int'(out_p), 3);

    // R4 own probe return
    @(negedge clk); t0 = now; in_v = 1; in_k = 2'd1; in_s = ME; in_t = 0;
    tick(); in_v = 0; in_k = 0;
    check(out_v && out_k == 2'd2 && out_s == ME, "R4 move kind", int'(out_k), 2);
    check(out_t == t0 + MARGIN, "R4 move time", int'(out_t), int'(t0 + MARGIN));

    // R5 initiator spin at scheduled time
    wait_spin(t0 + MARGIN, "R5 initiator spin");
    t1 = now;
    tick(); tick();
    check(out_v && out_k == 2'd3 && out_t == t1 + 1 + MARGIN, "R7 check-and-schedule", int'(out_t), int'(t1 + 1 + MARGIN));
    t1 = out_t;
    put_msg(2'd3, ME, t1);
    wait_spin(t1, "R7 second spin");
    @(negedge clk); blocked = 0;
    tick(); tick(); tick();
    check(!out_v, "R7 no message when unblocked", int'(out_v), 0);

    // R8 contention
    @(negedge clk); blocked = 1;
    edges_to_probe(n);
    check(n == THR + 1, "R2 restart after unblock", n, THR + 1);
    put_msg(2'd1, 4'd7, 16'd0);
    check(!out_v, "R8 higher id dropped", int'(out_v), 0);
    put_msg(2'd1, 4'd2, 16'd9);
    check(out_v && out_s == 4'd2, "R8 lower id forwarded", int'(out_s), 2);
    t1 = now + 40;
    put_msg(2'd2, 4'd9, t1);
    check(out_v && out_k == 2'd2 && out_s == 4'd9 && out_t == t1, "R5 foreign move forwarded", int'(out_t), int'(t1));
    put_msg(2'd1, 4'd2, 16'd0);
    check(!out_v, "R8 locked drops probe", int'(out_v), 0);
    wait_spin(t1, "R5 follower spin");
    tick();
    check(!spin_go, "R6 strobe one cycle", int'(spin_go), 0);
    n = 1;
    for (int i = 0; i < 100; i++) begin
      if (out_v && out_k == 2'd1 && out_s == ME) break;
      tick(); n++;
    end
    check(n == THR + 2, "R6 follower restart", n, THR + 2);

    // R9 timeout
    edges_to_probe(n);
    check(n == RET_TIMEOUT + THR + 1, "R9 timeout relaunch", n, RET_TIMEOUT + THR + 1);

    // R2 interrupted stall
    do_reset();
    @(negedge clk); blocked = 1;
    tick(); tick(); tick();
    @(negedge clk); blocked = 0;
    tick();
    check(!out_v, "R2 no early probe", int'(out_v), 0);
    @(negedge clk); blocked = 1;
    edges_to_probe(n);
    check(n == THR + 1, "R2 full threshold again", n, THR + 1);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule